// File: doc/BRIEF.md
# Two-Way Message Register Bank

This block gives a host bus and a local add-on bus a way to pass short commands and parameters to each other. It holds two groups of 32-bit message registers. The outgoing group is written and read back by the host and read by the add-on side. The incoming group is written by the add-on side and only read by the host. Both sides reach a register through a word index and four byte-lane enables, so 8-bit, 16-bit and 32-bit transfers all work. Both sides run in one clock domain. Read data comes back one cycle after the read strobe.

A per-register "full" flag tells each side when a message is waiting. The flag is set when the writer stores the most significant byte and cleared when the reader fetches that byte. The add-on side also owns one trigger register. For each direction it names one register and one byte lane and carries an enable bit. When an enabled host access touches that exact byte, a sticky status bit is set and the add-on interrupt line rises. The trigger is a host write for the outgoing group and a host read for the incoming group. The add-on side clears a status bit by writing 1 to it. The top byte of the last incoming register can be switched to show an external 8-bit input instead of its stored value.

The block has no state machine. The trigger register, the full flags and the registered read data are its only control state.

Top module: `mbx_bank`

## Requirements
- R1: A host write to an outgoing register (host index 0 to 3, index bit 2 clear) stores the enabled lanes. Both a later host read and an add-on read (add-on index 0 to 3) of that register return the stored value one cycle after the read strobe.
- R2: The add-on side writes incoming registers at add-on index 0 to 3, and the host reads them at host index 4 to 7. A host write to index 4 to 7 leaves the incoming contents unchanged.
- R3: Lane k of the byte enables covers data bits 8k+7:8k. A write changes only the enabled lanes. A read returns the enabled lanes and zeros in every disabled lane.
- R4: The trigger register sits at add-on index 4. Bits 1:0 select the outgoing register, bits 3:2 select its lane and bit 4 is the enable. When the enable is set, a host write to that register whose enables include that lane sets status bit 16. Any other host write, or any write while the enable is clear, leaves bit 16 unchanged.
- R5: In the trigger register, bits 9:8 select the incoming register, bits 11:10 select its lane and bit 12 is the enable. When the enable is set, a host read of that register whose enables include that lane sets status bit 17. Host writes never set bit 17.
- R6: Status bits stay set until the add-on side writes 1 to them (lane 2 enabled). The interrupt output is high in the cycle after a status bit is set and stays high while any status bit is set together with its enable. If a status set and its clear happen in the same cycle, the set wins.
- R7: While the pin-select input is high, bits 31:24 of incoming register 3 read as the external pin byte. While it is low, those bits read as the stored value.
- R8: Full flag i of a group is set by a write to register i whose enables include lane 3. It is cleared by a read from the other side of register i whose enables include lane 3. Other lanes do not change it.
- R9: If one side writes a register and the other side reads the same register in the same cycle, the read returns the newly written data. The full flag ends set, and an armed trigger still sets its status bit.
- R10: After reset the interrupt output, both full vectors, both read-data outputs and the trigger register all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host word index: 0 to 3 outgoing, 4 to 7 incoming |
| h_be | input | 4 | Host byte-lane enables |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after h_rd |
| a_addr | input | 3 | Add-on index: 0 to 3 message registers, 4 trigger register |
| a_be | input | 4 | Add-on byte-lane enables |
| a_wr | input | 1 | Add-on write strobe |
| a_rd | input | 1 | Add-on read strobe |
| a_wdata | input | 32 | Add-on write data |
| a_rdata | output | 32 | Add-on read data, valid the cycle after a_rd |
| pin_sel | input | 1 | Selects the pin byte for incoming register 3, lane 3 |
| pin_byte | input | 8 | External byte shown when pin_sel is high |
| out_full | output | 4 | Message-waiting flags of the outgoing registers |
| in_full | output | 4 | Message-waiting flags of the incoming registers |
| irq | output | 1 | Add-on interrupt |

## Verification
The message path is tested with full-word, single-byte and two-byte patterns. These show whether lanes are stored and masked independently or the whole word moves at once. Trigger tests touch the armed register on a different lane, touch a different register on the armed lane, and then hit the armed pair exactly. This shows whether both the register match and the lane match are applied. Full-flag tests use partial reads before the lane-3 read, and a final test issues a write and a read of the same register in one cycle. These show the set and clear conditions and the write-first rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int SEL_W  = 2;

    typedef logic [LANES-1:0]  be_t;
    typedef logic [WORD_W-1:0] word_t;

    // one trigger selection: register, lane, enable
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] lane;
        logic [SEL_W-1:0] mbx;
    } trig_t;

    function automatic word_t lane_mask(input be_t be);
        word_t m;
        for (int l = 0; l < LANES; l++)
            m[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
        return m;
    endfunction
endpackage

// File: rtl/mbx_lane_bank.sv
module mbx_lane_bank
    import mbx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  be_t                    wbe,
    input  word_t                  wdata,
    output word_t [DEPTH-1:0]      q,
    output word_t [DEPTH-1:0]      nx
);
    // next contents, visible to same-cycle readers (write first)
    always_comb begin
        nx = q;
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wbe[l])
                    nx[widx][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // message storage carries no reset value
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            q[g] <= nx[g];
        end
    end
endmodule

// File: rtl/mbx_full_track.sv
module mbx_full_track #(
    parameter int DEPTH = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_v,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_v,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [DEPTH-1:0] full
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        logic set_g, clr_g;
        assign set_g = set_v && (set_idx == IDX_W'(g));
        assign clr_g = clr_v && (clr_idx == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     full[g] <= 1'b0;
            else if (set_g) full[g] <= 1'b1;
            else if (clr_g) full[g] <= 1'b0;
        end
    end

    AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && !set_v) |=> !full[$past(clr_idx)]) else $error("full not cleared"); // R8
endmodule

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl
    import mbx_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  be_t              cfg_be,
    input  word_t            cfg_wdata,
    output word_t            cfg_rdata,
    input  logic             h_wr_out,
    input  logic             h_rd_in,
    input  logic [IDX_W-1:0] h_idx,
    input  be_t              h_be,
    output logic             irq
);
    trig_t trig_o, trig_i;
    logic  st_o, st_i;
    logic  hit_o, hit_i, clr_o, clr_i;

    assign hit_o = trig_o.en && h_wr_out && (SEL_W'(h_idx) == trig_o.mbx) && h_be[trig_o.lane];
    assign hit_i = trig_i.en && h_rd_in  && (SEL_W'(h_idx) == trig_i.mbx) && h_be[trig_i.lane];
    assign clr_o = cfg_we && cfg_be[2] && cfg_wdata[16];
    assign clr_i = cfg_we && cfg_be[2] && cfg_wdata[17];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_o <= '0;
            trig_i <= '0;
        end else if (cfg_we) begin
            if (cfg_be[0]) trig_o <= cfg_wdata[4:0];
            if (cfg_be[1]) trig_i <= cfg_wdata[12:8];
        end
    end

    // sticky status, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_o <= 1'b0;
            st_i <= 1'b0;
        end else begin
            if (hit_o)      st_o <= 1'b1;
            else if (clr_o) st_o <= 1'b0;
            if (hit_i)      st_i <= 1'b1;
            else if (clr_i) st_i <= 1'b0;
        end
    end

    assign irq       = (st_o && trig_o.en) || (st_i && trig_i.en);
    assign cfg_rdata = {14'b0, st_i, st_o, 3'b0, trig_i, 3'b0, trig_o};

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o && !clr_o) |=> st_o) else $error("status dropped"); // R6
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_o.en && !st_o) |=> !st_o) else $error("status set while disabled"); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit_o || hit_i || cfg_we)) else $error("irq without cause"); // R6
    AST_WRITE_NO_IN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_rd_in && !st_i) |=> !st_i) else $error("incoming status without read"); // R5
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int NUM_MBX = 4,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W:0]     h_addr,
    input  logic [LANES-1:0]   h_be,
    input  logic               h_wr,
    input  logic               h_rd,
    input  logic [WORD_W-1:0]  h_wdata,
    output logic [WORD_W-1:0]  h_rdata,
    input  logic [IDX_W:0]     a_addr,
    input  logic [LANES-1:0]   a_be,
    input  logic               a_wr,
    input  logic               a_rd,
    input  logic [WORD_W-1:0]  a_wdata,
    output logic [WORD_W-1:0]  a_rdata,
    input  logic               pin_sel,
    input  logic [LANE_W-1:0]  pin_byte,
    output logic [NUM_MBX-1:0] out_full,
    output logic [NUM_MBX-1:0] in_full,
    output logic               irq
);
    localparam int TOP_LANE = LANES - 1;
    localparam logic [IDX_W-1:0] PIN_IDX = IDX_W'(NUM_MBX - 1);

    logic [IDX_W-1:0] h_idx, a_idx;
    logic h_in, a_ctl;
    logic h_wr_out, h_wr_in, h_rd_in, h_rd_out;
    logic a_wr_in, a_rd_out, a_wr_ctl;
    word_t [NUM_MBX-1:0] ob_q, ob_nx, ib_q, ib_nx;
    word_t h_word, a_word, cfg_rdata, h_mask;
    word_t h_rdata_q, a_rdata_q;

    assign h_idx    = h_addr[IDX_W-1:0];
    assign h_in     = h_addr[IDX_W];
    assign a_idx    = a_addr[IDX_W-1:0];
    assign a_ctl    = a_addr[IDX_W];
    assign h_wr_out = h_wr && !h_in;
    assign h_wr_in  = h_wr && h_in;
    assign h_rd_out = h_rd && !h_in;
    assign h_rd_in  = h_rd && h_in;
    assign a_wr_in  = a_wr && !a_ctl;
    assign a_rd_out = a_rd && !a_ctl;
    assign a_wr_ctl = a_wr && a_ctl;
    assign h_mask   = lane_mask(h_be);

    mbx_lane_bank #(.DEPTH(NUM_MBX), .IDX_W(IDX_W)) u_out_bank (
        .clk(clk), .we(h_wr_out), .widx(h_idx), .wbe(h_be), .wdata(h_wdata),
        .q(ob_q), .nx(ob_nx)
    );

    mbx_lane_bank #(.DEPTH(NUM_MBX), .IDX_W(IDX_W)) u_in_bank (
        .clk(clk), .we(a_wr_in), .widx(a_idx), .wbe(a_be), .wdata(a_wdata),
        .q(ib_q), .nx(ib_nx)
    );

    mbx_full_track #(.DEPTH(NUM_MBX), .IDX_W(IDX_W)) u_out_full (
        .clk(clk), .rst_n(rst_n),
        .set_v(h_wr_out && h_be[TOP_LANE]), .set_idx(h_idx),
        .clr_v(a_rd_out && a_be[TOP_LANE]), .clr_idx(a_idx),
        .full(out_full)
    );

    mbx_full_track #(.DEPTH(NUM_MBX), .IDX_W(IDX_W)) u_in_full (
        .clk(clk), .rst_n(rst_n),
        .set_v(a_wr_in && a_be[TOP_LANE]), .set_idx(a_idx),
        .clr_v(h_rd_in && h_be[TOP_LANE]), .clr_idx(h_idx),
        .full(in_full)
    );

    mbx_irq_ctl #(.IDX_W(IDX_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(a_wr_ctl), .cfg_be(a_be), .cfg_wdata(a_wdata), .cfg_rdata(cfg_rdata),
        .h_wr_out(h_wr_out), .h_rd_in(h_rd_in), .h_idx(h_idx), .h_be(h_be),
        .irq(irq)
    );

    // host read source: next-state contents, pin byte override on the last incoming word
    always_comb begin
        if (h_in) begin
            h_word = ib_nx[h_idx];
            if (pin_sel && (h_idx == PIN_IDX))
                h_word[TOP_LANE*LANE_W +: LANE_W] = pin_byte;
        end else begin
            h_word = ob_nx[h_idx];
        end
    end

    assign a_word = a_ctl ? cfg_rdata : ob_nx[a_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata_q <= '0;
            a_rdata_q <= '0;
        end else begin
            h_rdata_q <= (h_rd_out || h_rd_in) ? (h_word & h_mask) : '0;
            a_rdata_q <= a_rd ? (a_word & lane_mask(a_be)) : '0;
        end
    end

    assign h_rdata = h_rdata_q;
    assign a_rdata = a_rdata_q;

    AST_IN_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_in && !a_wr_in) |-> (ib_nx == ib_q)) else $error("host changed incoming"); // R2
    AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_out && h_be[TOP_LANE]) |=> out_full[$past(h_idx)]) else $error("full not set"); // R8
    AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |=> ((h_rdata & ~$past(h_mask)) == '0)) else $error("disabled lane returned data"); // R3
endmodule

// File: tb/sim_mbx_bank.sv
module sim_mbx_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  h_addr = '0, a_addr = '0;
    logic [3:0]  h_be = '0, a_be = '0;
    logic        h_wr = 1'b0, h_rd = 1'b0, a_wr = 1'b0, a_rd = 1'b0;
    logic [31:0] h_wdata = '0, a_wdata = '0;
    logic [31:0] h_rdata, a_rdata;
    logic        pin_sel = 1'b0;
    logic [7:0]  pin_byte = '0;
    logic [3:0]  out_full, in_full;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] d;

    always #2.5 clk = ~clk;

    mbx_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_be(h_be), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .a_addr(a_addr), .a_be(a_be), .a_wr(a_wr), .a_rd(a_rd),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .pin_sel(pin_sel), .pin_byte(pin_byte),
        .out_full(out_full), .in_full(in_full), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] ad, input logic [3:0] be, input logic [31:0] v);
        @(negedge clk); h_addr = ad; h_be = be; h_wdata = v; h_wr = 1'b1;
        @(negedge clk); h_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] ad, input logic [3:0] be, output logic [31:0] v);
        @(negedge clk); h_addr = ad; h_be = be; h_rd = 1'b1;
        @(negedge clk); h_rd = 1'b0; v = h_rdata;
    endtask

    task automatic awr(input logic [2:0] ad, input logic [3:0] be, input logic [31:0] v);
        @(negedge clk); a_addr = ad; a_be = be; a_wdata = v; a_wr = 1'b1;
        @(negedge clk); a_wr = 1'b0;
    endtask

    task automatic ard(input logic [2:0] ad, input logic [3:0] be, output logic [31:0] v);
        @(negedge clk); a_addr = ad; a_be = be; a_rd = 1'b1;
        @(negedge clk); a_rd = 1'b0; v = a_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R10", "irq", {31'b0, irq}, 32'h0);
        chk("R10", "full vectors", {24'b0, out_full, in_full}, 32'h0);
        chk("R10", "read data", h_rdata | a_rdata, 32'h0);
        ard(3'd4, 4'hF, v);
        chk("R10", "trigger register", v, 32'h0);
    endtask

    task automatic t_outgoing;
        logic [31:0] v;
        hwr(3'd0, 4'hF, 32'hDEADBEEF);
        hrd(3'd0, 4'hF, v);
        chk("R1", "host readback mbox0", v, 32'hDEADBEEF);
        ard(3'd0, 4'hF, v);
        chk("R1", "add-on read mbox0", v, 32'hDEADBEEF);
        hwr(3'd3, 4'hF, 32'h0BADC0DE);
        ard(3'd3, 4'hF, v);
        chk("R1", "add-on read mbox3", v, 32'h0BADC0DE);
    endtask

    task automatic t_lanes;
        logic [31:0] v;
        hwr(3'd2, 4'hF, 32'h11223344);
        hwr(3'd2, 4'b0100, 32'hFFAAFFFF);
        hrd(3'd2, 4'hF, v);
        chk("R3", "byte write lane 2", v, 32'h11AA3344);
        hrd(3'd2, 4'b1100, v);
        chk("R3", "16-bit upper read", v, 32'h11AA0000);
        hrd(3'd2, 4'b0001, v);
        chk("R3", "byte read lane 0", v, 32'h00000044);
    endtask

    task automatic t_incoming;
        logic [31:0] v;
        awr(3'd1, 4'hF, 32'hCAFEF00D);
        hrd(3'd5, 4'hF, v);
        chk("R2", "host read incoming 1", v, 32'hCAFEF00D);
        hwr(3'd5, 4'hF, 32'hFFFFFFFF);
        hrd(3'd5, 4'hF, v);
        chk("R2", "host write ignored", v, 32'hCAFEF00D);
        awr(3'd1, 4'b0001, 32'h00000077);
        hrd(3'd5, 4'hF, v);
        chk("R3", "add-on byte write", v, 32'hCAFEF077);
    endtask

    task automatic t_out_irq;
        logic [31:0] v;
        awr(3'd4, 4'b0001, 32'h00000016);   // mbox 2, lane 1, enabled
        hwr(3'd2, 4'b0001, 32'h0);
        chk("R4", "wrong lane no irq", {31'b0, irq}, 32'h0);
        hwr(3'd1, 4'b0010, 32'h0);
        chk("R4", "wrong mbox no irq", {31'b0, irq}, 32'h0);
        hwr(3'd2, 4'b0010, 32'h0);
        chk("R4", "exact hit irq", {31'b0, irq}, 32'h1);
        ard(3'd4, 4'hF, v);
        chk("R4", "status bit 16", v, 32'h00010016);
        chk("R6", "irq sticky", {31'b0, irq}, 32'h1);
        awr(3'd4, 4'b0100, 32'h00010000);
        chk("R6", "W1C drops irq", {31'b0, irq}, 32'h0);
        awr(3'd4, 4'b0001, 32'h00000006);   // same selection, disabled
        hwr(3'd2, 4'b0010, 32'h0);
        chk("R4", "disabled no irq", {31'b0, irq}, 32'h0);
        ard(3'd4, 4'hF, v);
        chk("R4", "disabled status clear", v, 32'h00000006);
    endtask

    task automatic t_in_irq;
        logic [31:0] v;
        awr(3'd4, 4'b0010, 32'h00001D00);   // incoming 1, lane 3, enabled
        hrd(3'd5, 4'b0001, v);
        chk("R5", "wrong lane no irq", {31'b0, irq}, 32'h0);
        hwr(3'd5, 4'b1000, 32'h0);
        chk("R5", "host write no irq", {31'b0, irq}, 32'h0);
        hrd(3'd5, 4'b1000, v);
        chk("R5", "read hit irq", {31'b0, irq}, 32'h1);
        ard(3'd4, 4'hF, v);
        chk("R5", "status bit 17", v, 32'h00021D06);
        awr(3'd4, 4'b0100, 32'h00020000);
        chk("R6", "W1C drops irq", {31'b0, irq}, 32'h0);
        awr(3'd4, 4'b0010, 32'h0);
    endtask

    task automatic t_pins;
        logic [31:0] v;
        awr(3'd3, 4'hF, 32'h01020304);
        pin_byte = 8'h5A;
        hrd(3'd7, 4'hF, v);
        chk("R7", "pins deselected", v, 32'h01020304);
        pin_sel = 1'b1;
        hrd(3'd7, 4'hF, v);
        chk("R7", "pin byte shown", v, 32'h5A020304);
        hrd(3'd7, 4'b0111, v);
        chk("R7", "pin lane masked", v, 32'h00020304);
        pin_sel = 1'b0;
    endtask

    task automatic t_full;
        logic [31:0] v;
        ard(3'd0, 4'b1000, v);
        chk("R8", "out0 cleared", {31'b0, out_full[0]}, 32'h0);
        hwr(3'd0, 4'b0001, 32'h0);
        chk("R8", "low lane no set", {31'b0, out_full[0]}, 32'h0);
        hwr(3'd0, 4'b1000, 32'h0);
        chk("R8", "lane 3 sets", {31'b0, out_full[0]}, 32'h1);
        ard(3'd0, 4'b0111, v);
        chk("R8", "partial read keeps", {31'b0, out_full[0]}, 32'h1);
        ard(3'd0, 4'b1000, v);
        chk("R8", "lane 3 read clears", {31'b0, out_full[0]}, 32'h0);
        awr(3'd2, 4'b1000, 32'h0);
        chk("R8", "in2 set", {31'b0, in_full[2]}, 32'h1);
        hrd(3'd6, 4'b0001, v);
        chk("R8", "in2 partial keeps", {31'b0, in_full[2]}, 32'h1);
        hrd(3'd6, 4'b1000, v);
        chk("R8", "in2 cleared", {31'b0, in_full[2]}, 32'h0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        awr(3'd4, 4'b0001, 32'h0000001D);   // outgoing 1, lane 3, enabled
        ard(3'd1, 4'b1000, v);
        @(negedge clk);
        h_addr = 3'd1; h_be = 4'hF; h_wdata = 32'h12345678; h_wr = 1'b1;
        a_addr = 3'd1; a_be = 4'hF; a_rd = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; a_rd = 1'b0;
        chk("R9", "add-on sees new data", a_rdata, 32'h12345678);
        chk("R9", "out1 full kept", {31'b0, out_full[1]}, 32'h1);
        chk("R9", "event flagged", {31'b0, irq}, 32'h1);
        @(negedge clk);
        a_addr = 3'd2; a_be = 4'hF; a_wdata = 32'h9ABCDEF0; a_wr = 1'b1;
        h_addr = 3'd6; h_be = 4'hF; h_rd = 1'b1;
        @(negedge clk);
        a_wr = 1'b0; h_rd = 1'b0;
        chk("R9", "host sees new data", h_rdata, 32'h9ABCDEF0);
        chk("R9", "in2 full kept", {31'b0, in_full[2]}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_outgoing();
        t_lanes();
        t_incoming();
        t_out_irq();
        t_in_irq();
        t_pins();
        t_full();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule